// File: doc/BRIEF.md
# Serial Nibble Register Access Engine

This block is the bus master for a three-wire serial link to a timekeeping chip. It uses a serial clock, one data line that can be driven or released under a direction control, and a chip select that a higher-level sequencer owns. The engine itself never touches the chip select. Each transaction moves one 4-bit value to or from one of sixteen register addresses.

A host starts a transaction with a one-cycle start strobe. Alongside the strobe it presents a read/write select, an address and, for writes, a data nibble. The engine shifts out a fixed 16-bit frame. For a read it releases the data line after the first eight bits and captures the returned nibble. It signals the end with a one-cycle done pulse. The serial clock is divided down from the system clock, and each half-period lasts `HALF_CYC` system clocks.

Top module: `snib_engine`

## Requirements
- R1: A read frame first drives the control nibble 1,1,1,0 (don't-care, read flag = 1, address flag = 1, data flag = 0), then the address from bit 3 down to bit 0. Each bit is presented on `sdo` before the rising edge of `sclk`.
- R2: A read drives `sdo_en` high for serial bits 0..7 and low for bits 8..15. The four bits sampled at bits 8..11 are discarded. The bits sampled at bits 12..15 form `rdata[3:0]`, most significant bit first.
- R3: A write frame drives, with `sdo_en` high for all 16 bits, in this order: 1,0,1,0; then address bits 3..0; then 1,0,0,1; then data bits 3..0.
- R4: `sdo` and `sdo_en` never change while `sclk` is high. `sdi` is sampled at the system clock edge where `sclk` rises.
- R5: Every `sclk` high and low phase lasts exactly `HALF_CYC` system clocks. A frame is 16 serial clock periods, so `busy` stays high for exactly 32*`HALF_CYC` system clocks.
- R6: `busy` rises on the clock edge after an accepted start and falls in the cycle where `done` is high. A start that arrives while `busy` is high is ignored, and the frame in progress continues unchanged.
- R7: `done` is high for exactly one system clock, after the last serial bit. `rdata` changes only in a cycle where `done` is high after a read. A write leaves `rdata` as it was.
- R8: `sdo_en` changes only while `sclk` is low. It falls a full half-period before the first input sample.
- R9: During reset and after reset, `sclk`, `sdo`, `sdo_en`, `busy`, `done` and `rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transaction |
| rd_wr | input | 1 | 1 = read, 0 = write; sampled with start |
| addr | input | 4 | Register address; sampled with start |
| wdata | input | 4 | Write nibble; sampled with start |
| rdata | output | 4 | Nibble captured by the last completed read |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data driven toward the chip |
| sdo_en | output | 1 | 1 = data line driven by this block, 0 = released |
| sdi | input | 1 | Serial data returned from the chip |

## Verification
Writes go to the lowest and highest addresses with the all-zero, all-one and alternating nibbles. These show whether the two control nibbles are kept apart from the address and data fields, and whether any bit is reordered. Reads are answered by a peripheral model that returns the inverse of the register value during the four discarded slots. Capturing one slot early or late therefore gives a visibly wrong nibble. Writes placed between reads show that `rdata` holds. A second start issued in the middle of a read checks that the frame in progress is not disturbed. The checks also confirm that no extra transaction follows.

// File: rtl/snib_pkg.sv
package snib_pkg;

  localparam int NIB_W      = 4;
  localparam int FRAME_BITS = 16;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TURN_BIT   = 8;   // first bit with the data line released (read)
  localparam int CAPT_BIT   = 12;  // first bit kept in the read nibble

  // Control nibbles: don't-care, read flag, address flag, data flag
  localparam logic [NIB_W-1:0] CTL_RD_ADDR = 4'b1110;
  localparam logic [NIB_W-1:0] CTL_WR_ADDR = 4'b1010;
  localparam logic [NIB_W-1:0] CTL_WR_DATA = 4'b1001;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } seq_state_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic             rd,
    input logic [NIB_W-1:0] a,
    input logic [NIB_W-1:0] d
  );
    logic [FRAME_BITS-1:0] f;
    if (rd) f = {CTL_RD_ADDR, a, {(2*NIB_W){1'b0}}};
    else    f = {CTL_WR_ADDR, a, CTL_WR_DATA, d};
    return f;
  endfunction

endpackage

// File: rtl/snib_tick.sv
module snib_tick #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)               cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LAST);

  generate
    if (HALF_CYC > 1) begin : g_spacing
      // R5: two half-period boundaries never fall on adjacent cycles
      p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/snib_capture.sv
module snib_capture
  import snib_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp,
  input  logic             sdi,
  input  logic             commit,
  output logic [NIB_W-1:0] rdata
);
  logic [NIB_W-1:0] cap_q, cap_d;
  logic [NIB_W-1:0] hold_q, hold_d;

  always_comb begin
    cap_d  = cap_q;
    hold_d = hold_q;
    if (smp)    cap_d  = {cap_q[NIB_W-2:0], sdi};
    if (commit) hold_d = cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      hold_q <= '0;
    end else begin
      if (smp)    cap_q  <= cap_d;
      if (commit) hold_q <= hold_d;
    end
  end

  assign rdata = hold_q;

  // R7: the held nibble moves only on a read completion
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(hold_q));

endmodule

// File: rtl/snib_seq.sv
module snib_seq
  import snib_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_wr,
  input  logic [NIB_W-1:0] addr,
  input  logic [NIB_W-1:0] wdata,
  input  logic             tick,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             sdo,
  output logic             sdo_en,
  output logic             smp,
  output logic             commit
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_TURN = IDX_W'(TURN_BIT);
  localparam logic [IDX_W-1:0] IDX_CAPT = IDX_W'(CAPT_BIT);

  seq_state_t            st_q, st_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  rd_q, rd_d;
  logic                  sclk_q, sclk_d;
  logic                  oe_q, oe_d;
  logic                  done_q, done_d;
  logic [IDX_W-1:0]      idx_nx;

  assign idx_nx = idx_q + 1'b1;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    rd_d   = rd_q;
    sclk_d = sclk_q;
    oe_d   = oe_q;
    done_d = 1'b0;
    smp    = 1'b0;
    commit = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_LOW;
          idx_d = '0;
          sh_d  = build_frame(rd_wr, addr, wdata);
          rd_d  = rd_wr;
          oe_d  = 1'b1;
        end
      end
      ST_LOW: begin
        if (tick) begin
          sclk_d = 1'b1;
          st_d   = ST_HIGH;
          smp    = rd_q && (idx_q >= IDX_CAPT);
        end
      end
      ST_HIGH: begin
        if (tick) begin
          sclk_d = 1'b0;
          if (idx_q == IDX_LAST) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            oe_d   = 1'b0;
            sh_d   = '0;
            commit = rd_q;
          end else begin
            st_d  = ST_LOW;
            idx_d = idx_nx;
            sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
            oe_d  = !(rd_q && (idx_nx >= IDX_TURN));
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      sh_q   <= '0;
      rd_q   <= 1'b0;
      sclk_q <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      rd_q   <= rd_d;
      sclk_q <= sclk_d;
      oe_q   <= oe_d;
      done_q <= done_d;
    end
  end

  assign busy   = (st_q != ST_IDLE);
  assign done   = done_q;
  assign sclk   = sclk_q;
  assign sdo    = sh_q[FRAME_BITS-1];
  assign sdo_en = oe_q;

  // R4: driven data and direction hold while the serial clock is high
  p_sdo_hold_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> ($stable(sh_q[FRAME_BITS-1]) && $stable(oe_q)));
  // R8: direction moves only with the serial clock low
  p_dir_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !sclk_q);
  // R2: the line is released from the turnaround bit on during a read
  p_dir_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_q && (idx_q >= IDX_TURN)) |-> !oe_q);
  // R7: done lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R6: busy only ends together with done
  p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_q);
  // R9: serial clock stays low while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk_q && !oe_q));

endmodule

// File: rtl/snib_engine.sv
module snib_engine
  import snib_pkg::*;
#(
  parameter int HALF_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_wr,
  input  logic [NIB_W-1:0] addr,
  input  logic [NIB_W-1:0] wdata,
  output logic [NIB_W-1:0] rdata,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             sdo,
  output logic             sdo_en,
  input  logic             sdi
);
  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       tick, smp, commit;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  snib_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (busy),
    .tick  (tick)
  );

  snib_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (start),
    .rd_wr  (rd_wr),
    .addr   (addr),
    .wdata  (wdata),
    .tick   (tick),
    .busy   (busy),
    .done   (done),
    .sclk   (sclk),
    .sdo    (sdo),
    .sdo_en (sdo_en),
    .smp    (smp),
    .commit (commit)
  );

  snib_capture u_cap (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .smp    (smp),
    .sdi    (sdi),
    .commit (commit),
    .rdata  (rdata)
  );

  // R7: read data only moves in a done cycle
  p_rdata_done_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(rdata) |-> done);

endmodule

// File: tb/snib_engine_tb.sv
module snib_engine_tb;
  localparam int HALF = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       rd_wr = 1'b0;
  logic [3:0] addr = '0;
  logic [3:0] wdata = '0;
  logic       sdi = 1'b0;
  logic [3:0] rdata;
  logic       busy, done, sclk, sdo, sdo_en;

  always #2 clk = ~clk;  // 250 MHz

  snib_engine #(.HALF_CYC(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_wr(rd_wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy), .done(done), .sclk(sclk),
    .sdo(sdo), .sdo_en(sdo_en), .sdi(sdi)
  );

  int nchk = 0;
  int nerr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Peripheral model
  logic [3:0]  mem [16];
  logic [15:0] sw;
  logic [15:0] oe_w;
  int          sc = 0;

  always @(posedge busy) begin
    sc = 0; sw = '0; oe_w = '0;
  end
  always @(posedge sclk) begin
    if (sc < 16) begin
      sw[15-sc]   = sdo;
      oe_w[15-sc] = sdo_en;
    end
    sc++;
  end
  always @(negedge sclk) begin
    if (sc >= 8 && sc < 16 && sw[14]) begin
      if (sc < 12) sdi = ~mem[sw[11:8]][11-sc];
      else         sdi =  mem[sw[11:8]][15-sc];
    end
  end

  // Scoreboard
  typedef struct packed {
    logic       rd;
    logic [3:0] a;
    logic [3:0] d;
    logic [3:0] exp_rd;
  } item_t;
  item_t q[$];

  logic [3:0] last_rd = '0;
  int  bcnt = 0;
  bit  prev_done = 1'b0;
  bit  prev_sclk = 1'b0, prev_sdo = 1'b0, prev_oe = 1'b0;
  int  hi_len = 0, hi_bad = 0, hi_runs = 0, r4_bad = 0, r8_bad = 0;
  bit  mon_on = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (busy) bcnt++;
      if (sclk) hi_len++;
      if (prev_sclk && !sclk) begin
        hi_runs++;
        if (hi_len != HALF) hi_bad++;
        hi_len = 0;
      end
      if (sclk && prev_sclk && (sdo != prev_sdo)) r4_bad++;
      if (sclk && (sdo_en != prev_oe)) r8_bad++;
      if (done) begin
        item_t it;
        chk(!prev_done, "R7 done one cycle", int'(prev_done), 0);
        chk(!busy, "R6 busy low at done", int'(busy), 0);
        chk(bcnt == 32*HALF, "R5 frame length", bcnt, 32*HALF);
        if (q.size() == 0) begin
          chk(1'b0, "R6 unexpected transaction", 1, 0);
        end else begin
          it = q.pop_front();
          chk(sc == 16, "R5 serial clock count", sc, 16);
          if (it.rd) begin
            chk(sw[15:8] == {4'b1110, it.a}, "R1 read header", int'(sw[15:8]),
                int'({4'b1110, it.a}));
            chk(oe_w == 16'hFF00, "R2 direction pattern", int'(oe_w), 16'hFF00);
            chk(rdata == it.exp_rd, "R2 read nibble", int'(rdata), int'(it.exp_rd));
            last_rd = it.exp_rd;
          end else begin
            chk(sw == {4'b1010, it.a, 4'b1001, it.d}, "R3 write frame", int'(sw),
                int'({4'b1010, it.a, 4'b1001, it.d}));
            chk(oe_w == 16'hFFFF, "R3 direction pattern", int'(oe_w), 16'hFFFF);
            chk(rdata == last_rd, "R7 rdata held across write", int'(rdata),
                int'(last_rd));
          end
        end
        bcnt = 0;
      end
      prev_done = done;
      prev_sclk = sclk;
      prev_sdo  = sdo;
      prev_oe   = sdo_en;
    end
  end

  task automatic pulse_start(input bit rd, input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    start = 1'b1; rd_wr = rd; addr = a; wdata = d;
    @(negedge clk);
    start = 1'b0; rd_wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic txn(input bit rd, input logic [3:0] a, input logic [3:0] d,
                     input bit poke);
    item_t it;
    it.rd = rd; it.a = a; it.d = d; it.exp_rd = mem[a];
    q.push_back(it);
    if (!rd) mem[a] = d;
    pulse_start(rd, a, d);
    if (poke) begin
      repeat (10) @(negedge clk);
      pulse_start(~rd, ~a, ~d);  // R6: must be ignored
    end
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 4'(i) ^ 4'h5;
    fork
      begin
        repeat (3) @(negedge clk);
        chk(!sclk && !busy && !done && !sdo_en && !sdo && rdata == 0,
            "R9 state in reset", int'({sclk, busy, done, sdo_en, sdo}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!sclk && !busy && !done && !sdo_en && !sdo && rdata == 0,
            "R9 state after reset", int'({sclk, busy, done, sdo_en, sdo, rdata}), 0);
        mon_on = 1'b1;
        txn(1'b0, 4'h0, 4'h0, 1'b0);
        txn(1'b0, 4'hF, 4'hF, 1'b0);
        txn(1'b1, 4'hF, 4'h0, 1'b0);
        txn(1'b0, 4'h6, 4'h9, 1'b0);
        txn(1'b1, 4'h0, 4'h0, 1'b0);
        txn(1'b1, 4'h6, 4'h0, 1'b0);
        txn(1'b1, 4'hA, 4'h0, 1'b1);
        repeat (6 * HALF) @(negedge clk);
        chk(!busy && q.size() == 0, "R6 start during busy ignored", int'(busy), 0);
        txn(1'b0, 4'h3, 4'h6, 1'b0);
        txn(1'b1, 4'h3, 4'h0, 1'b0);
        txn(1'b1, 4'hC, 4'h0, 1'b0);
        chk(hi_bad == 0 && hi_runs > 0, "R5 high phase length", hi_bad, 0);
        chk(r4_bad == 0, "R4 data stable while sclk high", r4_bad, 0);
        chk(r8_bad == 0, "R8 direction stable while sclk high", r8_bad, 0);
      end
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule